// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block judges whether a phase-locked loop has settled, working only from the phase error seen on each phase-detector cycle. The loop's up and down pulses are combined off-block into one active-low error level: it is low while either pulse is active, so its low time is the real phase error plus the antibacklash pulse. The block samples this level with a fast sample clock, passes it through a synchronizer, and measures each low interval in whole sample ticks. It then compares each measurement with two programmable limits: a narrow lock window and a wider loss-of-lock threshold.

The limits give hysteresis. While unlocked, a run of consecutive in-window cycles (three or five, chosen by one control pin) is needed before the lock flag goes high. Any out-of-window cycle on the way resets the run. Once locked, errors up to the loss threshold keep the flag high, and a single cycle beyond it drops the flag at once. A phase-detector cycle marker input lets a cycle with no error pulse at all count as a zero-error cycle. All pins are plain control and status. There is no data stream, so no valid/ready handshake and no back-pressure.

Top module: `pll_lock_detect`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) forces `locked` low and clears the consecutive-cycle run. After reset, lock again needs a full run.
- R2: Each low interval of `err_n` yields one measurement equal to the number of sample-clock edges at which `err_n` was sampled low. The measurement passes through a two-flop synchronizer. `locked` reflects a measurement within 3 sample cycles after `err_n` returns high.
- R3: With `need_five` = 0, three consecutive measurements less than or equal to `win_ticks` raise `locked`.
- R4: With `need_five` = 1, five consecutive in-window measurements are needed to raise `locked`.
- R5: While unlocked, a measurement greater than `win_ticks` clears the run to zero.
- R6: While locked, a single measurement greater than `loss_ticks` drops `locked` to 0 and clears the run.
- R7: While locked, measurements greater than `win_ticks` but not greater than `loss_ticks` leave `locked` high.
- R8: Both comparisons are inclusive of the limit: a width equal to `win_ticks` counts as in-window, and a width equal to `loss_ticks` does not drop lock.
- R9: A `cyc_tick` pulse with no completed error pulse since the previous `cyc_tick` is evaluated as a zero-width, in-window measurement.
- R10: Measured widths saturate at 2^W-1 ticks (255 with W=8). A longer pulse compares as 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| err_n | input | 1 | Active-low phase-error level, asynchronous |
| cyc_tick | input | 1 | One-cycle marker per phase-detector cycle, synchronous to clk |
| need_five | input | 1 | 0: run of 3 in-window cycles; 1: run of 5 |
| win_ticks | input | W | Lock window in sample ticks |
| loss_ticks | input | W | Loss-of-lock threshold in sample ticks, not below win_ticks |
| locked | output | 1 | Lock flag, high while the loop is judged locked |

## Verification
The assertions assume that `loss_ticks` is never below `win_ticks`, and that the limits and `need_five` change only while no measurement is in flight. They also assume that `cyc_tick` never arrives in the same cycle as the end of an error pulse. The stimulus holds the limits fixed across each sweep and changes them only during idle gaps or reset. It drives every error pulse at least one sample tick wide, and spaces `cyc_tick` well clear of pulse edges. Expected flags come from a small arithmetic model in the bench that follows the run-count and threshold rules.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_st_e;

  function automatic int unsigned run_goal(input logic five,
                                           input int unsigned lo,
                                           input int unsigned hi);
    return five ? hi : lo;
  endfunction
endpackage

// File: rtl/pld_sync.sv
module pld_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pld_meter.sv
module pld_meter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lvl,
  input  logic         cyc_tick,
  output logic         meas_vld,
  output logic [W-1:0] meas_w
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic         prev;
  logic         seen;
  logic [W-1:0] cnt;
  logic         done;
  logic         zero_ev;

  // rising edge of the synchronized level closes a pulse
  assign done    = lvl && !prev;
  assign zero_ev = cyc_tick && !seen && lvl && prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev     <= 1'b1;
      seen     <= 1'b0;
      cnt      <= '0;
      meas_vld <= 1'b0;
      meas_w   <= '0;
    end else begin
      prev <= lvl;
      if (!lvl) begin
        if (prev)               cnt <= CNT_ONE;
        else if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
      end
      meas_vld <= done || zero_ev;
      meas_w   <= done ? cnt : '0;
      if (cyc_tick)  seen <= 1'b0;
      else if (done) seen <= 1'b1;
    end
  end

  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl) |=> meas_vld); // R2
  AST_WIDTH_NONZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl) |=> (meas_w != '0)); // R2
  AST_IDLE_TICK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cyc_tick && !seen && lvl && prev) |=> (meas_vld && meas_w == '0)); // R9
endmodule

// File: rtl/pld_lock_fsm.sv
module pld_lock_fsm
  import pld_pkg::*;
#(
  parameter int W       = 8,
  parameter int RUN_LO  = 3,
  parameter int RUN_HI  = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ev_vld,
  input  logic [W-1:0] ev_w,
  input  logic [W-1:0] win,
  input  logic [W-1:0] loss,
  input  logic         need_five,
  output logic         locked
);
  localparam int CW = $clog2(RUN_HI + 1);

  lock_st_e      st;
  logic [CW-1:0] run;
  logic [CW-1:0] goal;
  logic          in_win;
  logic          beyond;

  assign goal   = CW'(run_goal(need_five, RUN_LO, RUN_HI));
  assign in_win = (ev_w <= win);
  assign beyond = (ev_w > loss);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_HUNT;
      run <= '0;
    end else if (ev_vld) begin
      case (st)
        ST_HUNT: begin
          if (!in_win) begin
            run <= '0;
          end else if (run + CW'(1) >= goal) begin
            st  <= ST_LOCK;
            run <= '0;
          end else begin
            run <= run + CW'(1);
          end
        end
        default: begin
          if (beyond) begin
            st  <= ST_HUNT;
            run <= '0;
          end
        end
      endcase
    end
  end

  assign locked = (st == ST_LOCK);

  AST_ENTRY_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(ev_vld && (ev_w <= win))); // R3
  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    run < CW'(RUN_HI)); // R4
  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!locked && ev_vld && ev_w > win) |=> (run == '0 && !locked)); // R5
  AST_LOSS_DROPS: assert property (@(posedge clk) disable iff (rst)
    (locked && ev_vld && ev_w > loss) |=> !locked); // R6
  AST_HOLD_BELOW_LOSS: assert property (@(posedge clk) disable iff (rst)
    (locked && !(ev_vld && ev_w > loss)) |=> locked); // R7
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LO      = 3,
  parameter int RUN_HI      = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         err_n,
  input  logic         cyc_tick,
  input  logic         need_five,
  input  logic [W-1:0] win_ticks,
  input  logic [W-1:0] loss_ticks,
  output logic         locked
);
  logic         lvl;
  logic         meas_vld;
  logic [W-1:0] meas_w;

  pld_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (err_n),
    .q   (lvl)
  );

  pld_meter #(.W(W)) meter_i (
    .clk      (clk),
    .rst      (rst),
    .lvl      (lvl),
    .cyc_tick (cyc_tick),
    .meas_vld (meas_vld),
    .meas_w   (meas_w)
  );

  pld_lock_fsm #(.W(W), .RUN_LO(RUN_LO), .RUN_HI(RUN_HI)) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .ev_vld    (meas_vld),
    .ev_w      (meas_w),
    .win       (win_ticks),
    .loss      (loss_ticks),
    .need_five (need_five),
    .locked    (locked)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !locked); // R1
endmodule

// File: tb/pll_lock_detect_tb_top.sv
module pll_lock_detect_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst = 1'b1;
  logic         err_n = 1'b1;
  logic         tick = 1'b0;
  logic         five = 1'b0;
  logic [W-1:0] win = 8'd4;
  logic [W-1:0] loss = 8'd8;
  logic         locked;

  int checks = 0;
  int errors = 0;
  bit lk_m = 0;
  int run_m = 0;
  bit seen_m = 0;

  pll_lock_detect #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .err_n(err_n), .cyc_tick(tick),
    .need_five(five), .win_ticks(win), .loss_ticks(loss), .locked(locked)
  );

  function automatic void model(int w);
    int goal = five ? 5 : 3;
    int we = (w > 255) ? 255 : w;
    if (!lk_m) begin
      if (we <= int'(win)) begin
        if (run_m + 1 >= goal) begin lk_m = 1; run_m = 0; end
        else run_m = run_m + 1;
      end else run_m = 0;
    end else if (we > int'(loss)) begin
      lk_m = 0; run_m = 0;
    end
  endfunction

  task automatic chk(bit exp, string tag);
    checks++;
    if (locked !== exp) begin
      errors++;
      $display("FAIL %s locked=%0b expected=%0b", tag, locked, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    lk_m = 0; run_m = 0; seen_m = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(int len, string tag);
    @(negedge clk) err_n = 1'b0;
    repeat (len) @(negedge clk);
    err_n = 1'b1;
    repeat (8) @(negedge clk);
    model(len);
    seen_m = 1;
    chk(lk_m, tag);
  endtask

  task automatic tick_once(string tag);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (5) @(negedge clk);
    if (!seen_m) model(0);
    seen_m = 0;
    chk(lk_m, tag);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk(1'b0, "R1 reset state");

    // R3 / R4: sweep widths under both run lengths
    for (int f = 0; f < 2; f++) begin
      for (int w = 1; w <= 10; w++) begin
        five = f[0];
        do_reset();
        for (int k = 0; k < 6; k++) pulse(w, f ? "R4 sweep" : "R3 sweep");
      end
    end
    five = 1'b0;

    // R2: width measurement against a window of 6
    win = 8'd6; loss = 8'd12;
    do_reset();
    pulse(6, "R2 width 6"); pulse(6, "R2 width 6"); pulse(6, "R2 width 6");
    chk(1'b1, "R2 exact width locks");
    do_reset();
    pulse(7, "R2 width 7"); pulse(7, "R2 width 7"); pulse(7, "R2 width 7");
    chk(1'b0, "R2 one tick over stays unlocked");
    win = 8'd4; loss = 8'd8;

    // R5: miss resets the run
    do_reset();
    pulse(2, "R5"); pulse(2, "R5"); pulse(5, "R5 miss");
    pulse(2, "R5"); pulse(2, "R5");
    chk(1'b0, "R5 run restarted");
    pulse(2, "R5 third after miss");
    chk(1'b1, "R5 locks after full run");

    // R6 / R7: locked hysteresis sweep
    for (int w = 5; w <= 9; w++) begin
      do_reset();
      pulse(1, "R7 setup"); pulse(1, "R7 setup"); pulse(1, "R7 setup");
      pulse(w, (w > 8) ? "R6 drop" : "R7 hold");
      pulse(w, (w > 8) ? "R6 after drop" : "R7 hold again");
    end

    // R8: inclusive limits
    do_reset();
    pulse(4, "R8 window edge"); pulse(4, "R8 window edge"); pulse(4, "R8 window edge");
    chk(1'b1, "R8 equal to window locks");
    pulse(8, "R8 loss edge");
    chk(1'b1, "R8 equal to loss holds");

    // R9: idle cycles count as zero error
    do_reset();
    tick_once("R9 idle"); tick_once("R9 idle"); tick_once("R9 idle");
    chk(1'b1, "R9 three idle cycles lock");
    pulse(9, "R9 drop"); tick_once("R9 tick after pulse");
    chk(1'b0, "R9 tick after pulse is not an idle cycle");

    // R10: saturation
    loss = 8'd254;
    do_reset();
    pulse(1, "R10 setup"); pulse(1, "R10 setup"); pulse(1, "R10 setup");
    pulse(254, "R10 at 254 holds");
    pulse(300, "R10 saturated drop");
    chk(1'b0, "R10 saturated width exceeds 254");
    loss = 8'd8;

    // R1: reset mid-lock
    do_reset();
    pulse(1, "R1 setup"); pulse(1, "R1 setup"); pulse(1, "R1 setup");
    do_reset();
    chk(1'b0, "R1 reset clears lock");
    pulse(1, "R1 run cleared"); pulse(1, "R1 run cleared");
    chk(1'b0, "R1 two pulses after reset insufficient");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule